// File: doc/BRIEF.md
# Paged Buffer Write Controller

The controller takes a stream of front-end data words, one per cycle, and writes them into a buffer memory cut into fixed pages of 2^P words. It never picks page addresses itself. Buffer-manager software loads empty page addresses into a free-page queue, and the controller takes the head entry when the first word of a new page arrives. Each page it finishes goes into a used-page queue, which the software drains. A used-page entry holds the page address, how many words were written, and whether an end-of-event marker closed the page.

A registered XOFF output asks the data source to pause. It is high from reset and stays high while software keeps the enable low. Once enabled, XOFF follows whether the free-page queue holds fewer entries than a programmable threshold. A word that arrives when no page is open and no free page is available is dropped, and a sticky overflow flag is raised that only software can clear. If the used-page queue is full when a page closes, the close is parked and input is refused until software pops an entry.

Top module: `paged_buf_wr`

## Requirements
- R1: After reset, xoff is 1, in_ready is 1, up_valid is 0, ovf is 0 and mem_we is 0.
- R2: A word accepted on the rising edge where in_valid and in_ready are both 1 appears on mem_we/mem_addr/mem_data one cycle later. mem_addr is {page, offset}, with the page in the upper PA bits and the word offset in the lower P bits. The offset starts at 0 on each new page and increments by one per word.
- R3: When the 2^P-th word of a page is written, the page closes and an entry with up_count equal to 2^P and up_eoe equal to 0 is pushed to the used-page queue. The entry is visible on up_valid/up_page/up_count/up_eoe one cycle after that word's handshake.
- R4: A word with in_eoe set closes its page even when the page is not full. The entry carries up_count equal to the number of words in the page (the marker word included) and up_eoe equal to 1. The next word starts a new page.
- R5: A free page is taken only when the first word after a close is accepted, so idle cycles leave the free-page occupancy unchanged. Pages are used in the order software pushed them.
- R6: xoff is the registered value of (!cfg_enable || free occupancy < threshold). It is updated on the edge after the enable, the threshold register or the occupancy changes. cfg_thr_we loads cfg_thr into the threshold register, whose reset value is THR_RST.
- R7: A word accepted with no page open and an empty free-page queue causes no memory write and sets ovf. ovf stays set until an ovf_clr cycle clears it on the next edge.
- R8: If a page closes while the used-page queue is full, the closing word is still written, in_ready goes to 0 and further words are refused. After an up_pop frees a slot, the held entry is pushed on the next edge and in_ready returns to 1, with the queue order kept.
- R9: fp_push while the free-page queue already holds FP_DEPTH entries is ignored. up_pop while the used-page queue is empty has no effect.
- R10: While the used-page queue has room, in_ready stays 1 and one word is accepted every cycle, across page boundaries included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word present |
| in_data | input | DW | Input word |
| in_eoe | input | 1 | Word is the last of an event |
| in_ready | output | 1 | Controller takes the word on this edge |
| fp_push | input | 1 | Software pushes a free page address |
| fp_addr | input | PA | Free page address |
| up_pop | input | 1 | Software removes the head used-page entry |
| up_valid | output | 1 | Used-page queue not empty |
| up_page | output | PA | Head entry: page address |
| up_count | output | P+1 | Head entry: words written |
| up_eoe | output | 1 | Head entry: closed by end-of-event marker |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | PA+P | Buffer memory word address |
| mem_data | output | DW | Buffer memory write data |
| cfg_enable | input | 1 | Software enable of data flow |
| cfg_thr_we | input | 1 | Load the threshold register |
| cfg_thr | input | TW | New threshold value |
| ovf | output | 1 | Sticky lost-word flag |
| ovf_clr | input | 1 | Clears ovf |
| xoff | output | 1 | Pause request to the data source |

## Verification
Memory write outputs, used-page entries, ovf and the fall of in_ready all belong to the edge that takes the word. The bench drives each word at a falling edge and reads these results at the next falling edge. xoff sits one register behind the free-page count and the threshold register, so it is due two edges after a word that takes a page or after a threshold write, and one edge after an enable change. The bench samples at exactly that point, and for R5 it also checks the value just before, so the latency is confirmed as well. When a parked close is released, in_ready is checked on both the edge after the pop (still 0) and the one after that (1).

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  timeunit 1ns; timeprecision 1ps;
  localparam int unsigned PBW_DW       = 16;
  localparam int unsigned PBW_PA       = 4;
  localparam int unsigned PBW_P        = 2;
  localparam int unsigned PBW_FP_DEPTH = 8;
  localparam int unsigned PBW_UP_DEPTH = 4;
  localparam int unsigned PBW_THR_RST  = 2;
endpackage

// File: rtl/pbw_fifo.sv
module pbw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     level
);
  timeunit 1ns; timeprecision 1ps;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign full    = (lvl_q == CW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign level   = lvl_q;
  assign dout    = store[rd_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + AW'(1);
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + AW'(1);
    if (do_push && !do_pop)      lvl_d = lvl_q + CW'(1);
    else if (do_pop && !do_push) lvl_d = lvl_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) store[wr_q] <= din;
  end
endmodule

// File: rtl/pbw_xoff.sv
module pbw_xoff #(
  parameter int LW      = 4,
  parameter int THR_RST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          thr_we,
  input  logic [LW-1:0] thr_in,
  input  logic [LW-1:0] level,
  output logic          xoff
);
  timeunit 1ns; timeprecision 1ps;
  logic [LW-1:0] thr_q, thr_d;
  logic          xoff_q, xoff_d;

  always_comb begin
    thr_d  = thr_we ? thr_in : thr_q;
    xoff_d = !enable || (level < thr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= LW'(THR_RST);
      xoff_q <= 1'b1;
    end else begin
      thr_q  <= thr_d;
      xoff_q <= xoff_d;
    end
  end

  assign xoff = xoff_q;
endmodule

// File: rtl/pbw_page_writer.sv
module pbw_page_writer #(
  parameter int DW = 16,
  parameter int PA = 4,
  parameter int P  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_data,
  input  logic                 in_eoe,
  output logic                 in_ready,
  input  logic                 fp_empty,
  input  logic [PA-1:0]        fp_head,
  output logic                 fp_pop,
  input  logic                 up_full,
  output logic                 up_push,
  output logic [PA+P+1:0]      up_entry,
  output logic                 mem_we,
  output logic [PA+P-1:0]      mem_addr,
  output logic [DW-1:0]        mem_data,
  input  logic                 ovf_clr,
  output logic                 ovf
);
  timeunit 1ns; timeprecision 1ps;
  localparam int CW = P + 1;
  localparam int EW = PA + CW + 1;
  localparam int AW = PA + P;
  localparam logic [P-1:0] OFF_LAST = {P{1'b1}};

  // control state
  logic          open_q, open_d;
  logic          hold_q, hold_d;
  logic          ovf_q, ovf_d;
  logic          we_q, we_d;
  logic [P-1:0]  off_q, off_d;
  // datapath state
  logic [PA-1:0] page_q, page_d;
  logic [EW-1:0] held_q, held_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  logic          accept, wr, drop, last;
  logic [PA-1:0] cur_page;
  logic [P-1:0]  cur_off;
  logic [CW-1:0] cnt;
  logic [EW-1:0] entry;

  always_comb begin
    accept   = in_valid && !hold_q;
    wr       = accept && (open_q || !fp_empty);
    drop     = accept && !open_q && fp_empty;
    fp_pop   = accept && !open_q && !fp_empty;
    cur_page = open_q ? page_q : fp_head;
    cur_off  = open_q ? off_q : '0;
    last     = wr && (in_eoe || (cur_off == OFF_LAST));
    cnt      = CW'(cur_off) + CW'(1);
    entry    = {cur_page, cnt, in_eoe};
    up_push  = hold_q ? !up_full : (last && !up_full);
    up_entry = hold_q ? held_q : entry;
  end

  always_comb begin
    open_d = open_q;
    page_d = page_q;
    off_d  = off_q;
    if (wr) begin
      open_d = !last;
      page_d = cur_page;
      off_d  = cur_off + P'(1);
    end
    hold_d = hold_q;
    held_d = held_q;
    if (hold_q && !up_full) begin
      hold_d = 1'b0;
    end else if (last && up_full) begin
      hold_d = 1'b1;
      held_d = entry;
    end
    ovf_d  = drop ? 1'b1 : (ovf_clr ? 1'b0 : ovf_q);
    we_d   = wr;
    addr_d = wr ? {cur_page, cur_off} : addr_q;
    data_d = wr ? in_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      hold_q <= 1'b0;
      ovf_q  <= 1'b0;
      we_q   <= 1'b0;
      off_q  <= '0;
    end else begin
      open_q <= open_d;
      hold_q <= hold_d;
      ovf_q  <= ovf_d;
      we_q   <= we_d;
      off_q  <= off_d;
    end
  end

  always_ff @(posedge clk) begin
    page_q <= page_d;
    held_q <= held_d;
    addr_q <= addr_d;
    data_q <= data_d;
  end

  assign in_ready = !hold_q;
  assign mem_we   = we_q;
  assign mem_addr = addr_q;
  assign mem_data = data_q;
  assign ovf      = ovf_q;
endmodule

// File: rtl/paged_buf_wr.sv
module paged_buf_wr #(
  parameter int DW       = pbw_pkg::PBW_DW,
  parameter int PA       = pbw_pkg::PBW_PA,
  parameter int P        = pbw_pkg::PBW_P,
  parameter int FP_DEPTH = pbw_pkg::PBW_FP_DEPTH,
  parameter int UP_DEPTH = pbw_pkg::PBW_UP_DEPTH,
  parameter int THR_RST  = pbw_pkg::PBW_THR_RST,
  localparam int TW      = $clog2(FP_DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  input  logic            in_eoe,
  output logic            in_ready,
  input  logic            fp_push,
  input  logic [PA-1:0]   fp_addr,
  input  logic            up_pop,
  output logic            up_valid,
  output logic [PA-1:0]   up_page,
  output logic [P:0]      up_count,
  output logic            up_eoe,
  output logic            mem_we,
  output logic [PA+P-1:0] mem_addr,
  output logic [DW-1:0]   mem_data,
  input  logic            cfg_enable,
  input  logic            cfg_thr_we,
  input  logic [TW-1:0]   cfg_thr,
  output logic            ovf,
  input  logic            ovf_clr,
  output logic            xoff
);
  timeunit 1ns; timeprecision 1ps;
  localparam int CW = P + 1;
  localparam int EW = PA + CW + 1;
  localparam int UW = $clog2(UP_DEPTH) + 1;

  logic [1:0]    rst_sync;
  logic          rst_n_s;
  logic          fp_empty, fp_full, fp_pop;
  logic [PA-1:0] fp_head;
  logic [TW-1:0] fp_level;
  logic          up_full, up_empty, up_push;
  logic [EW-1:0] up_entry, up_head;
  logic [UW-1:0] up_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  pbw_fifo #(.W(PA), .DEPTH(FP_DEPTH)) u_free (
    .clk(clk), .rst_n(rst_n_s), .push(fp_push), .din(fp_addr), .pop(fp_pop),
    .dout(fp_head), .full(fp_full), .empty(fp_empty), .level(fp_level)
  );

  pbw_fifo #(.W(EW), .DEPTH(UP_DEPTH)) u_used (
    .clk(clk), .rst_n(rst_n_s), .push(up_push), .din(up_entry), .pop(up_pop),
    .dout(up_head), .full(up_full), .empty(up_empty), .level(up_level)
  );

  pbw_page_writer #(.DW(DW), .PA(PA), .P(P)) u_wr (
    .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .in_data(in_data),
    .in_eoe(in_eoe), .in_ready(in_ready), .fp_empty(fp_empty), .fp_head(fp_head),
    .fp_pop(fp_pop), .up_full(up_full), .up_push(up_push), .up_entry(up_entry),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .ovf_clr(ovf_clr), .ovf(ovf)
  );

  pbw_xoff #(.LW(TW), .THR_RST(THR_RST)) u_xoff (
    .clk(clk), .rst_n(rst_n_s), .enable(cfg_enable), .thr_we(cfg_thr_we),
    .thr_in(cfg_thr), .level(fp_level), .xoff(xoff)
  );

  assign up_valid = !up_empty;
  assign up_page  = up_head[EW-1 -: PA];
  assign up_count = up_head[1 +: CW];
  assign up_eoe   = up_head[0];
endmodule

// File: rtl/pbw_chk.sv
module pbw_chk #(
  parameter int P = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       mem_we,
  input logic       ovf,
  input logic       cfg_enable,
  input logic       xoff,
  input logic       up_valid,
  input logic [P:0] up_count,
  input logic       up_eoe,
  input logic       up_full
);
  timeunit 1ns; timeprecision 1ps;
  localparam logic [P:0] PAGE_WORDS = (P+1)'(1 << P);

  // R6
  xoff_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_enable) |-> xoff);

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(in_valid && in_ready));

  // R10
  accept_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (mem_we || ovf));

  // R8
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !up_full) |=> in_ready);

  // R8
  hold_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(up_full));

  // R3
  full_page_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_eoe) |-> (up_count == PAGE_WORDS));

  // R4
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> (up_count != '0 && up_count <= PAGE_WORDS));
endmodule

bind paged_buf_wr pbw_chk #(.P(P)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .in_ready(in_ready),
  .mem_we(mem_we), .ovf(ovf), .cfg_enable(cfg_enable), .xoff(xoff),
  .up_valid(up_valid), .up_count(up_count), .up_eoe(up_eoe), .up_full(up_full)
);

// File: tb/sim_paged_buf_wr.sv
module sim_paged_buf_wr;
  timeunit 1ns; timeprecision 1ps;
  localparam int DW = 16, PA = 4, P = 2, FPD = 8, UPD = 4, TW = 4;
  localparam int PW = 1 << P;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_eoe, in_ready;
  logic [DW-1:0] in_data;
  logic fp_push, up_pop, up_valid, up_eoe, mem_we;
  logic [PA-1:0] fp_addr, up_page;
  logic [P:0] up_count;
  logic [PA+P-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic cfg_enable, cfg_thr_we, ovf, ovf_clr, xoff;
  logic [TW-1:0] cfg_thr;

  always #2.5 clk = ~clk;

  paged_buf_wr #(.DW(DW), .PA(PA), .P(P), .FP_DEPTH(FPD), .UP_DEPTH(UPD), .THR_RST(2)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_eoe(in_eoe),
    .in_ready(in_ready), .fp_push(fp_push), .fp_addr(fp_addr), .up_pop(up_pop),
    .up_valid(up_valid), .up_page(up_page), .up_count(up_count), .up_eoe(up_eoe),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .cfg_enable(cfg_enable),
    .cfg_thr_we(cfg_thr_we), .cfg_thr(cfg_thr), .ovf(ovf), .ovf_clr(ovf_clr), .xoff(xoff)
  );

  int total = 0, bad = 0;
  bit done = 0;
  // bench model
  int  m_free[$];
  int  e_page[$];
  int  e_cnt[$];
  bit  e_eoe[$];
  bit  m_open = 0, m_en = 0;
  int  m_page = 0, m_off = 0, m_thr = 2;

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_xoff();
    return !m_en || (m_free.size() < m_thr);
  endfunction

  task automatic idle(input int n);
    in_valid = 0; in_eoe = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic free_push(input int a);
    fp_push = 1; fp_addr = PA'(a);
    @(negedge clk);
    fp_push = 0;
    if (m_free.size() < FPD) m_free.push_back(a); // R9: extra push dropped
  endtask

  task automatic set_thr(input int v);
    cfg_thr = TW'(v); cfg_thr_we = 1;
    @(negedge clk);
    cfg_thr_we = 0; m_thr = v;
  endtask

  task automatic send(input logic [DW-1:0] d, input bit e);
    bit acc;
    in_valid = 1; in_data = d; in_eoe = e;
    acc = in_ready;
    @(negedge clk);
    if (!acc) begin
      chk_eq("R8", "no write while held", mem_we, 0);
      return;
    end
    if (!m_open) begin
      if (m_free.size() == 0) begin
        chk_eq("R7", "dropped word not written", mem_we, 0);
        chk_eq("R7", "ovf set on drop", ovf, 1);
        return;
      end
      m_page = m_free.pop_front();
      m_off = 0;
      m_open = 1;
    end
    chk_eq("R2", "mem_we", mem_we, 1);
    chk_eq("R2", "mem_addr", mem_addr, m_page * PW + m_off);
    chk_eq("R2", "mem_data", mem_data, d);
    m_off++;
    if (e || m_off == PW) begin
      e_page.push_back(m_page); e_cnt.push_back(m_off); e_eoe.push_back(e);
      m_open = 0;
    end
  endtask

  task automatic pop_one(input bit recycle);
    int pg;
    pg = e_page.pop_front();
    chk_eq("R3", "up_valid", up_valid, 1);
    chk_eq(e_eoe[0] ? "R4" : "R3", "up_page", up_page, pg);
    chk_eq(e_eoe[0] ? "R4" : "R3", "up_count", up_count, e_cnt[0]);
    chk_eq("R4", "up_eoe", up_eoe, e_eoe[0]);
    void'(e_cnt.pop_front()); void'(e_eoe.pop_front());
    up_pop = 1;
    @(negedge clk);
    up_pop = 0;
    if (recycle) free_push(pg);
  endtask

  task automatic drain(input bit recycle);
    while (up_valid) pop_one(recycle);
    chk_eq("R3", "no entry missing", e_page.size(), 0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7321);
    rst_n = 0; in_valid = 0; in_eoe = 0; in_data = '0;
    fp_push = 0; fp_addr = '0; up_pop = 0;
    cfg_enable = 0; cfg_thr_we = 0; cfg_thr = '0; ovf_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_eq("R1", "xoff", xoff, 1);
    chk_eq("R1", "in_ready", in_ready, 1);
    chk_eq("R1", "up_valid", up_valid, 0);
    chk_eq("R1", "ovf", ovf, 0);
    chk_eq("R1", "mem_we", mem_we, 0);

    // load pages; ninth push overflows the 8-deep queue (R9)
    free_push(1); free_push(4); free_push(6); free_push(9);
    free_push(10); free_push(12); free_push(14); free_push(15);
    free_push(0);
    idle(2);
    chk_eq("R6", "xoff while disabled", xoff, 1);
    // R9 pop on empty used queue
    up_pop = 1; @(negedge clk); up_pop = 0;
    chk_eq("R9", "pop on empty", up_valid, 0);

    cfg_enable = 1; m_en = 1;
    @(negedge clk);
    chk_eq("R6", "xoff after enable", xoff, exp_xoff());
    set_thr(8); @(negedge clk);
    chk_eq("R6", "threshold equal count", xoff, 0);
    set_thr(9); @(negedge clk);
    chk_eq("R6", "threshold above count", xoff, 1);
    set_thr(2); @(negedge clk);
    chk_eq("R6", "threshold back low", xoff, 0);

    // random bursts, recycling pages
    for (int it = 0; it < 60; it++) begin
      int len;
      len = 1 + int'($urandom % 3);
      for (int k = 0; k < len; k++) begin
        chk_eq("R10", "ready in burst", in_ready, 1);
        send(DW'($urandom), ($urandom % 4) == 0);
      end
      idle(1 + int'($urandom % 2));
      drain(1);
    end

    // R10 long back-to-back run across page boundaries
    for (int k = 0; k < 12; k++) begin
      chk_eq("R10", "ready back-to-back", in_ready, 1);
      send(DW'(16'h5a00 + k), 0);
    end
    idle(1);
    drain(1);

    // R5 no page taken while idle
    if (m_open) begin send(16'h00ee, 1); idle(1); drain(1); end
    idle(1);
    set_thr(m_free.size());
    idle(3);
    chk_eq("R5", "idle keeps free count", xoff, 0);
    send(16'h1234, 0);
    chk_eq("R6", "xoff one reg behind", xoff, 0);
    idle(1);
    chk_eq("R6", "xoff after page taken", xoff, 1);
    set_thr(2);
    idle(1);

    // R8 used queue full holds the close
    send(16'h0a01, 1);
    send(16'h0a02, 1);
    send(16'h0a03, 1);
    send(16'h0a04, 1);
    send(16'h0a05, 1);
    chk_eq("R8", "ready low when held", in_ready, 0);
    send(16'h0bad, 0);
    send(16'h0bad, 0);
    idle(1);
    chk_eq("R8", "still held", in_ready, 0);
    pop_one(0);
    chk_eq("R8", "ready one edge after pop", in_ready, 0);
    @(negedge clk);
    chk_eq("R8", "ready restored", in_ready, 1);
    drain(1);

    // R7 run out of pages
    while (m_free.size() > 0 || m_open) begin
      send(DW'($urandom), 1);
      idle(1);
      drain(0);
    end
    idle(1);
    chk_eq("R6", "xoff with empty free queue", xoff, 1);
    send(16'hdead, 0);
    send(16'hbeef, 0);
    idle(2);
    chk_eq("R7", "ovf sticky", ovf, 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    chk_eq("R7", "ovf cleared", ovf, 0);
    free_push(13);
    send(16'h7777, 1);
    idle(1);
    drain(0);
    chk_eq("R7", "ovf stays clear", ovf, 0);

    // R6 disable again
    cfg_enable = 0; m_en = 0;
    @(negedge clk);
    chk_eq("R6", "xoff after disable", xoff, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule